// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block captures pin-change events for one bank of general-purpose pins and turns them into a single interrupt request. Each pin has a two-bit trigger code that selects the edge to watch for: rising only, falling only, either edge, or none. Level-sensitive detection does not exist. A matching edge sets that pin's sticky status bit. The bit stays set until software writes a one to it.

A per-pin mask register controls which status bits reach the request line. Software updates it through two separate addresses. Writing ones at the set address masks those pins. Writing ones at the clear address unmasks them. Both addresses read back the current mask. The request line is high whenever any status bit is set and its mask bit is clear. Masked pins still record their events.

The pin inputs are already synchronized to the block clock. Register access is a simple single-cycle bus. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `gpio_edge_irq_bank`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1 and `irqReq` is 0; software initialization (all ones written to the mask-set address, then all ones to the status address) returns the block to that same state.
- R2: With trigger code 1 (bits 2i+1:2i of `trigType` for pin i), a 0-to-1 change of the pin sets its status bit at the clock edge that first samples the new level, and a 1-to-0 change does not.
- R3: With trigger code 2 a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R4: With trigger code 3 both a 0-to-1 and a 1-to-0 change set the status bit.
- R5: With trigger code 0 no pin change ever sets the status bit.
- R6: A write to the status address (0x80 + 4*BANK_ID) clears exactly the status bits whose write-data bit is 1; other bits are left unchanged.
- R7: If an edge on a pin is detected in the same cycle as a status write with a 1 in that pin's bit, the status bit ends up set.
- R8: A write to the mask-set address (0xA0 + 4*BANK_ID) sets the mask bits whose data bit is 1 and keeps the others.
- R9: A write to the mask-clear address (0xC0 + 4*BANK_ID) clears the mask bits whose data bit is 1 and keeps the others.
- R10: `irqReq` is 1 exactly when some pin has its status bit set and its mask bit clear.
- R11: A masked pin still sets its status bit on a matching edge.
- R12: Reading the status address returns status. Reading either mask address returns the mask. Reading any other address returns 0, and writes to any other address change neither register.
- R13: Pin levels already present when reset is released are not reported as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pinLevel | input | NUM_PINS | Synchronized pin levels |
| trigType | input | 2*NUM_PINS | Per-pin trigger code, pin i at bits 2i+1:2i (0 off, 1 rise, 2 fall, 3 both) |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busWrData | input | NUM_PINS | Write data |
| busRdData | output | NUM_PINS | Read data for `busAddr` |
| irqReq | output | 1 | Bank interrupt request |

## Verification
Several behaviours are checked on every clock. A status bit may only appear after a change on its pin. It may only disappear through a status write that names it. Mask writes must take effect one edge later. The request must stay low while every pin is masked. The bench's scenarios cover the rest. These include the choice of edge for each trigger code and the race between an edge and a clear on the same bit. They also cover silence after reset with a pin held high, reads of unmapped addresses, and the software initialization sequence. A behavioural model is compared against the request line and the read data on every cycle.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_ANY  = 2'd3
  } trigCode_e;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   clrStatus;
    logic   setMask;
    logic   clrMask;
    rdSel_e rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/edge_irq_decode.sv
module edge_irq_decode
  import edge_irq_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int BANK_ID       = 0,
  parameter int STATUS_BASE   = 'h80,
  parameter int MASK_SET_BASE = 'hA0,
  parameter int MASK_CLR_BASE = 'hC0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output bankStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR   = ADDR_W'(STATUS_BASE + 4 * BANK_ID);
  localparam logic [ADDR_W-1:0] MASK_SET_ADDR = ADDR_W'(MASK_SET_BASE + 4 * BANK_ID);
  localparam logic [ADDR_W-1:0] MASK_CLR_ADDR = ADDR_W'(MASK_CLR_BASE + 4 * BANK_ID);

  logic hitStatus, hitMaskSet, hitMaskClr;

  always_comb begin
    hitStatus  = (busAddr == STATUS_ADDR);
    hitMaskSet = (busAddr == MASK_SET_ADDR);
    hitMaskClr = (busAddr == MASK_CLR_ADDR);

    strobe.clrStatus = busWrEn && hitStatus;
    strobe.setMask   = busWrEn && hitMaskSet;
    strobe.clrMask   = busWrEn && hitMaskClr;

    if (hitStatus)                    strobe.rdSel = RD_STATUS;
    else if (hitMaskSet || hitMaskClr) strobe.rdSel = RD_MASK;
    else                              strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinLevel,
  input  logic [2*NUM_PINS-1:0] trigType,
  input  logic [NUM_PINS-1:0]   busWrData,
  input  bankStrobe_t           strobe,
  output logic [NUM_PINS-1:0]   busRdData,
  output logic [NUM_PINS-1:0]   statusVec,
  output logic [NUM_PINS-1:0]   maskVec,
  output logic                  irqReq
);

  logic [NUM_PINS-1:0] prevLevel;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] clrBits;
  logic                armed;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [1:0] code;
    logic       rise, fall;
    always_comb begin
      code = trigType[2*g +: 2];
      rise = armed && pinLevel[g] && !prevLevel[g];
      fall = armed && !pinLevel[g] && prevLevel[g];
      case (code)
        TRIG_RISE: edgeHit[g] = rise;
        TRIG_FALL: edgeHit[g] = fall;
        TRIG_ANY:  edgeHit[g] = rise || fall;
        default:   edgeHit[g] = 1'b0;
      endcase
    end
  end

  assign clrBits = strobe.clrStatus ? busWrData : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLevel <= '0;
      armed     <= 1'b0;
      statusVec <= '0;
      maskVec   <= '1;
    end else begin
      prevLevel <= pinLevel;
      armed     <= 1'b1;
      statusVec <= (statusVec & ~clrBits) | edgeHit;
      if (strobe.setMask)      maskVec <= maskVec | busWrData;
      else if (strobe.clrMask) maskVec <= maskVec & ~busWrData;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_STATUS: busRdData = statusVec;
      RD_MASK:   busRdData = maskVec;
      default:   busRdData = '0;
    endcase
  end

  assign irqReq = |(statusVec & ~maskVec);

endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS      = 32,
  parameter int ADDR_W        = 12,
  parameter int BANK_ID       = 0,
  parameter int STATUS_BASE   = 'h80,
  parameter int MASK_SET_BASE = 'hA0,
  parameter int MASK_CLR_BASE = 'hC0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinLevel,
  input  logic [2*NUM_PINS-1:0] trigType,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [NUM_PINS-1:0]   busWrData,
  output logic [NUM_PINS-1:0]   busRdData,
  output logic                  irqReq
);

  bankStrobe_t         strobe;
  logic [NUM_PINS-1:0] statusVec;
  logic [NUM_PINS-1:0] maskVec;

  edge_irq_decode #(
    .ADDR_W(ADDR_W), .BANK_ID(BANK_ID), .STATUS_BASE(STATUS_BASE),
    .MASK_SET_BASE(MASK_SET_BASE), .MASK_CLR_BASE(MASK_CLR_BASE)
  ) u_decode (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe(strobe)
  );

  edge_irq_datapath #(.NUM_PINS(NUM_PINS)) u_datapath (
    .clk(clk),
    .rst_n(rst_n),
    .pinLevel(pinLevel),
    .trigType(trigType),
    .busWrData(busWrData),
    .strobe(strobe),
    .busRdData(busRdData),
    .statusVec(statusVec),
    .maskVec(maskVec),
    .irqReq(irqReq)
  );

endmodule

// File: rtl/gpio_edge_irq_bank_chk.sv
module gpio_edge_irq_bank_chk #(
  parameter int NUM_PINS      = 32,
  parameter int ADDR_W        = 12,
  parameter int BANK_ID       = 0,
  parameter int STATUS_BASE   = 'h80,
  parameter int MASK_SET_BASE = 'hA0,
  parameter int MASK_CLR_BASE = 'hC0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [NUM_PINS-1:0] busWrData,
  input logic                irqReq,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] maskVec
);

  localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_BASE + 4 * BANK_ID);
  localparam logic [ADDR_W-1:0] MS_ADDR = ADDR_W'(MASK_SET_BASE + 4 * BANK_ID);
  localparam logic [ADDR_W-1:0] MC_ADDR = ADDR_W'(MASK_CLR_BASE + 4 * BANK_ID);

  logic wrStatus, wrMaskSet, wrMaskClr;
  assign wrStatus  = busWrEn && (busAddr == ST_ADDR);
  assign wrMaskSet = busWrEn && (busAddr == MS_ADDR);
  assign wrMaskClr = busWrEn && (busAddr == MC_ADDR);

  // R1: registers hold their reset values on the first edge out of reset
  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (statusVec == '0 && maskVec == '1 && !irqReq));

  // R5: a status bit can only become set after its pin changed level
  a_r5_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (statusVec & ~$past(statusVec) & ~($past(pinLevel) ^ $past(pinLevel, 2))) == '0);

  // R6: a status bit can only drop through a status write with a 1 there
  a_r6_clear_only_by_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((~statusVec & $past(statusVec)) &
     ~($past(wrStatus) ? $past(busWrData) : {NUM_PINS{1'b0}})) == '0);

  // R8: mask-set write takes effect on the next edge
  a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrMaskSet |=> ((maskVec & $past(busWrData)) == $past(busWrData)));

  // R9: mask-clear write takes effect on the next edge
  a_r9_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wrMaskClr |=> ((maskVec & $past(busWrData)) == '0));

  // R10: a fully masked bank never requests
  a_r10_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (maskVec == '1) |-> !irqReq);

endmodule

bind gpio_edge_irq_bank gpio_edge_irq_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BANK_ID(BANK_ID),
  .STATUS_BASE(STATUS_BASE), .MASK_SET_BASE(MASK_SET_BASE), .MASK_CLR_BASE(MASK_CLR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pinLevel(pinLevel), .busAddr(busAddr),
  .busWrEn(busWrEn), .busWrData(busWrData), .irqReq(irqReq),
  .statusVec(statusVec), .maskVec(maskVec)
);

// File: tb/gpio_edge_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_bank_tb;

  localparam int N = 32;
  localparam logic [11:0] ST = 12'h080;
  localparam logic [11:0] MS = 12'h0A0;
  localparam logic [11:0] MC = 12'h0C0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pinLevel = 32'h0000_0020;
  logic [2*N-1:0] trigType;
  logic [11:0]   busAddr = 12'h000;
  logic          busWrEn = 1'b0;
  logic [N-1:0]  busWrData = '0;
  logic [N-1:0]  busRdData;
  logic          irqReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_edge_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pinLevel(pinLevel), .trigType(trigType),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqReq(irqReq)
  );

  // trigger codes: pin0 rise, pin1 fall, pin2 both, pin3 off, rest rise
  initial begin
    for (int i = 0; i < N; i++) trigType[2*i +: 2] = 2'd1;
    trigType[3:2] = 2'd2;
    trigType[5:4] = 2'd3;
    trigType[7:6] = 2'd0;
  end

  // behavioural reference model
  bit [N-1:0] mStatus = '0;
  bit [N-1:0] mMask = '1;
  bit [N-1:0] mPrev = '0;
  bit         mArmed = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mStatus = '0; mMask = '1; mPrev = '0; mArmed = 0;
    end else begin
      bit [N-1:0] ev;
      ev = '0;
      for (int i = 0; i < N; i++) begin
        int code;
        bit up, dn;
        code = trigType[2*i +: 2];
        up = mArmed && pinLevel[i] && !mPrev[i];
        dn = mArmed && !pinLevel[i] && mPrev[i];
        if ((code == 1 && up) || (code == 2 && dn) || (code == 3 && (up || dn))) ev[i] = 1;
      end
      if (busWrEn && busAddr == ST) mStatus = mStatus & ~busWrData;
      mStatus = mStatus | ev;
      if (busWrEn && busAddr == MS) mMask = mMask | busWrData;
      if (busWrEn && busAddr == MC) mMask = mMask & ~busWrData;
      mPrev = pinLevel;
      mArmed = 1;
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #5;
    if (rst_n && !finished) begin
      bit [N-1:0] expRd;
      if (busAddr == ST) expRd = mStatus;
      else if (busAddr == MS || busAddr == MC) expRd = mMask;
      else expRd = '0;
      check("R10 model irq", {31'b0, irqReq}, {31'b0, |(mStatus & ~mMask)});
      check("R12 model read", busRdData, expRd);
    end
  end

  task automatic wr(logic [11:0] a, logic [N-1:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdChk(string req, logic [11:0] a, logic [N-1:0] exp);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #6;
    check(req, busRdData, exp);
  endtask

  task automatic irqChk(string req, logic exp);
    @(negedge clk);
    #6;
    check(req, {31'b0, irqReq}, {31'b0, exp});
  endtask

  task automatic pins(logic [N-1:0] v);
    @(negedge clk);
    pinLevel = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R13 pin5 held high through reset gives no event
    rdChk("R1 status after reset", ST, 32'h0);
    rdChk("R1 mask after reset", MS, 32'hFFFF_FFFF);
    irqChk("R1 irq after reset", 1'b0);
    rdChk("R13 no event from reset level", ST, 32'h0);

    wr(MC, 32'hFFFF_FFFF);
    rdChk("R9 mask cleared", MC, 32'h0);

    pins(32'h0000_002F);
    rdChk("R2 R4 R5 rising pattern", ST, 32'h0000_0005);
    irqChk("R10 irq with unmasked status", 1'b1);

    wr(ST, 32'h1);
    rdChk("R6 clear only bit0", ST, 32'h0000_0004);
    wr(ST, 32'h4);
    rdChk("R6 clear bit2", ST, 32'h0);
    irqChk("R10 irq drops", 1'b0);

    pins(32'h0000_0020);
    rdChk("R3 R4 falling pattern", ST, 32'h0000_0006);
    wr(ST, 32'hFFFF_FFFF);

    wr(MS, 32'h2);
    rdChk("R8 mask set bit1", MS, 32'h2);
    wr(MS, 32'h100);
    rdChk("R8 mask set keeps others", MS, 32'h102);
    rdChk("R12 mask readable at clear address", MC, 32'h102);

    pins(32'h0000_0022);
    pins(32'h0000_0020);
    rdChk("R11 masked pin records event", ST, 32'h2);
    irqChk("R10 masked status gives no irq", 1'b0);
    wr(MC, 32'h2);
    rdChk("R9 mask clear keeps others", MS, 32'h100);
    irqChk("R10 unmask raises irq", 1'b1);
    wr(ST, 32'hFFFF_FFFF);

    pins(32'h0000_0060);
    rdChk("R2 pin6 rise", ST, 32'h40);
    // R7: edge on bit0 in the same cycle as its clear
    @(negedge clk);
    pinLevel = 32'h0000_0061;
    busAddr = ST; busWrEn = 1'b1; busWrData = 32'h41;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
    rdChk("R7 edge wins over clear", ST, 32'h1);

    rdChk("R12 unmapped reads zero", 12'h084, 32'h0);
    wr(12'h084, 32'hFFFF_FFFF);
    rdChk("R12 unmapped write leaves status", ST, 32'h1);
    rdChk("R12 unmapped write leaves mask", MS, 32'h100);

    wr(MS, 32'hFFFF_FFFF);
    wr(ST, 32'hFFFF_FFFF);
    rdChk("R1 init mask", MS, 32'hFFFF_FFFF);
    rdChk("R1 init status", ST, 32'h0);
    irqChk("R1 init irq", 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule